// File: doc/BRIEF.md
# Nibble-Serial Command Port Slave

This block is the slave end of a byte-wide command port that gives an external master access to a 64-entry, 8-bit register space. The master selects the port with a 3-bit port address and writes bytes with a write strobe. Each byte is either an address byte, which names a register and a direction, or a data byte, which carries a single 4-bit nibble. A register value is therefore written as two data bytes, upper half first. The block assembles the two halves and commits the value to the register file. After each accepted byte the block lowers READY for a set time, and the master waits for READY to return high before it sends another byte.

A read request places the register contents on the output bus. The block then pulls the active-low interrupt line to tell the master that the data is waiting. The master ends the read with a read strobe.

The block also watches six side event inputs, which share the same interrupt line. While a read is outstanding, the line belongs to that read alone. Events that fire in the meantime are latched and shown later, lowest index first. While an event is being shown, the output bus carries its index.

Top module: `nibcmd_port`

## Requirements
- R1: The block accepts a byte only when wrStrobe is high, portSel equals 3'b100 and readyOut is high at a rising clock edge. A strobe on any other port value leaves readyOut high and does not change the write state or any register.
- R2: In an accepted byte, bit 7 = 1 marks an address byte and bit 7 = 0 a data byte. In an address byte, bit 6 = 1 requests a read, bit 6 = 0 requests a write, and bits 5:0 give the register index.
- R3: After a write address byte, the first data byte supplies value bits 7:4 from its bits 3:0, and the second supplies value bits 3:0. Bits 6:4 of a data byte are ignored. The register is written on the edge that accepts the second data byte.
- R4: Each further pair of data bytes writes another value to the same register. The register index does not advance.
- R5: An address byte that arrives while a value is half-assembled discards both the pending address and the upper half. No register is written.
- R6: A data byte accepted when no write address is active (after reset or after a read request) is ignored.
- R7: readyOut is high after reset. It goes low on the edge that accepts a byte and stays low for READY_GAP cycles (default 2). A strobe while readyOut is low is ignored.
- R8: After a read request is accepted, busOut holds the register value with busOe high. intN goes low on the second edge after acceptance.
- R9: A read strobe with portSel = 3'b100 while a read is shown ends the read, and intN is high after the next edge. A read strobe on another port value has no effect.
- R10: Event pulses on evtIn are latched while a read is outstanding and are not shown. Once the line is free, the lowest-index latched event drives intN low, with busOut = the event index (zero-extended) and busOe high. Each event is cleared by a read strobe on port 3'b100.
- R11: After reset, intN is high, busOe is low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| portSel | input | 3 | Port address; 3'b100 selects the command port |
| busIn | input | 8 | Byte written by the master |
| wrStrobe | input | 1 | Write strobe, sampled on the rising edge |
| rdStrobe | input | 1 | Read strobe; ends a shown read or event |
| evtIn | input | 6 | Side event pulses, index 0 has the highest priority |
| busOut | output | 8 | Read data or event index |
| busOe | output | 1 | High while busOut carries valid data |
| readyOut | output | 1 | High when the next byte may be sent |
| intN | output | 1 | Active-low interrupt |

## Verification
The bench targets cases where a small slip in the write sequencer shows up as a wrong register value:
- An address byte after a lone upper nibble must drop that nibble. A design that kept it would write a mixed value or write the wrong register.
- A second nibble pair must land in the same register. A design that incremented the index would corrupt the next register.
- A strobe sent while READY is low, or on another port, must not count. A design that accepted it would start a new address or take a stray nibble.

A further test fires two events during a read. They must stay hidden until the read strobe, then appear in index order. A design without exclusive ownership of the line would drop the read data or show events in the wrong order.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam int REG_ADDR_W = 6;
  localparam int BYTE_W     = 8;
  localparam int NIB_W      = 4;

  typedef struct packed {
    logic takeAddr;
    logic takeHi;
    logic commitLo;
    logic loadRead;
  } cmdStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_WAIT_LO
  } wrState_t;
endpackage

// File: rtl/nibcmd_ctrl.sv
module nibcmd_ctrl
  import nibcmd_pkg::*;
#(
  parameter int          READY_GAP = 2,
  parameter int          NUM_EVT   = 6,
  parameter logic [2:0]  PORT_CODE = 3'b100,
  localparam int         CNT_W     = $clog2(READY_GAP + 1),
  localparam int         IDX_W     = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         portSel,
  input  logic [1:0]         kindBits,
  input  logic               wrStrobe,
  input  logic               rdStrobe,
  input  logic [NUM_EVT-1:0] evtIn,
  output cmdStrobe_t         strobe,
  output logic               readyOut,
  output logic               intN,
  output logic               showRead,
  output logic               evtActive,
  output logic [IDX_W-1:0]   evtIdx
);

  wrState_t          wrState;
  logic [CNT_W-1:0]  gapCnt;
  logic              readBusy;
  logic [NUM_EVT-1:0] evtPend;
  logic [IDX_W-1:0]  pickIdx;
  logic              pickFound;
  logic              portHit;
  logic              accept;
  logic              rdHit;

  assign portHit  = (portSel == PORT_CODE);
  assign readyOut = (gapCnt == '0);
  assign accept   = wrStrobe && portHit && readyOut;
  assign rdHit    = rdStrobe && portHit;

  always_comb begin
    strobe.takeAddr = accept && kindBits[1] && !kindBits[0];
    strobe.loadRead = accept && kindBits[1] && kindBits[0];
    strobe.takeHi   = accept && !kindBits[1] && (wrState == ST_WAIT_HI);
    strobe.commitLo = accept && !kindBits[1] && (wrState == ST_WAIT_LO);
  end

  // write sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrState <= ST_IDLE;
    end else if (strobe.takeAddr) begin
      wrState <= ST_WAIT_HI;
    end else if (strobe.loadRead) begin
      wrState <= ST_IDLE;
    end else if (strobe.takeHi) begin
      wrState <= ST_WAIT_LO;
    end else if (strobe.commitLo) begin
      wrState <= ST_WAIT_HI;
    end
  end

  // handshake hold-off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (accept) begin
      gapCnt <= CNT_W'(READY_GAP);
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end
  end

  // read ownership of the interrupt line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readBusy <= 1'b0;
      showRead <= 1'b0;
    end else if (strobe.loadRead) begin
      readBusy <= 1'b1;
      showRead <= 1'b0;
    end else if (showRead && rdHit) begin
      readBusy <= 1'b0;
      showRead <= 1'b0;
    end else if (readBusy) begin
      showRead <= 1'b1;
    end
  end

  always_comb begin
    pickIdx   = '0;
    pickFound = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evtPend[i] && !pickFound) begin
        pickIdx   = IDX_W'(i);
        pickFound = 1'b1;
      end
    end
  end

  // side events: latch, prioritise, present
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtPend   <= '0;
      evtActive <= 1'b0;
      evtIdx    <= '0;
    end else begin
      if (strobe.loadRead && evtActive) begin
        evtPend           <= evtPend | evtIn;
        evtPend[evtIdx]   <= 1'b1;
        evtActive         <= 1'b0;
      end else if (evtActive && rdHit && !readBusy) begin
        evtPend   <= evtPend | evtIn;
        evtActive <= 1'b0;
      end else if (!evtActive && !readBusy && pickFound) begin
        evtPend          <= evtPend | evtIn;
        evtPend[pickIdx] <= evtIn[pickIdx];
        evtActive        <= 1'b1;
        evtIdx           <= pickIdx;
      end else begin
        evtPend <= evtPend | evtIn;
      end
    end
  end

  assign intN = !(showRead || evtActive);

endmodule

// File: rtl/nibcmd_dp.sv
module nibcmd_dp
  import nibcmd_pkg::*;
#(
  parameter int  NUM_EVT = 6,
  localparam int DEPTH   = 1 << REG_ADDR_W,
  localparam int IDX_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] cmdField,
  input  cmdStrobe_t            strobe,
  input  logic                  showRead,
  input  logic                  evtActive,
  input  logic [IDX_W-1:0]      evtIdx,
  output logic [BYTE_W-1:0]     busOut,
  output logic                  busOe
);

  logic [REG_ADDR_W-1:0] wAddr;
  logic [NIB_W-1:0]      hiNib;
  logic [BYTE_W-1:0]     regFile [DEPTH];
  logic [BYTE_W-1:0]     outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wAddr <= '0;
      hiNib <= '0;
    end else begin
      if (strobe.takeAddr) wAddr <= cmdField;
      if (strobe.takeHi)   hiNib <= cmdField[NIB_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
    end else if (strobe.commitLo) begin
      regFile[wAddr] <= {hiNib, cmdField[NIB_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobe.loadRead) begin
      outReg <= regFile[cmdField];
    end
  end

  always_comb begin
    busOe  = showRead || evtActive;
    busOut = '0;
    if (showRead) begin
      busOut = outReg;
    end else if (evtActive) begin
      busOut = {{(BYTE_W-IDX_W){1'b0}}, evtIdx};
    end
  end

endmodule

// File: rtl/nibcmd_port.sv
module nibcmd_port
  import nibcmd_pkg::*;
#(
  parameter int         READY_GAP = 2,
  parameter int         NUM_EVT   = 6,
  parameter logic [2:0] PORT_CODE = 3'b100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         portSel,
  input  logic [7:0]         busIn,
  input  logic               wrStrobe,
  input  logic               rdStrobe,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [7:0]         busOut,
  output logic               busOe,
  output logic               readyOut,
  output logic               intN
);

  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  cmdStrobe_t       strobe;
  logic             showRead;
  logic             evtActive;
  logic [IDX_W-1:0] evtIdx;

  nibcmd_ctrl #(
    .READY_GAP (READY_GAP),
    .NUM_EVT   (NUM_EVT),
    .PORT_CODE (PORT_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .portSel   (portSel),
    .kindBits  (busIn[7:6]),
    .wrStrobe  (wrStrobe),
    .rdStrobe  (rdStrobe),
    .evtIn     (evtIn),
    .strobe    (strobe),
    .readyOut  (readyOut),
    .intN      (intN),
    .showRead  (showRead),
    .evtActive (evtActive),
    .evtIdx    (evtIdx)
  );

  nibcmd_dp #(
    .NUM_EVT (NUM_EVT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmdField  (busIn[REG_ADDR_W-1:0]),
    .strobe    (strobe),
    .showRead  (showRead),
    .evtActive (evtActive),
    .evtIdx    (evtIdx),
    .busOut    (busOut),
    .busOe     (busOe)
  );

endmodule

// File: rtl/nibcmd_port_chk.sv
module nibcmd_port_chk #(
  parameter logic [2:0] PORT_CODE = 3'b100
) (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] portSel,
  input logic [7:0] busIn,
  input logic       wrStrobe,
  input logic       rdStrobe,
  input logic       busOe,
  input logic       readyOut,
  input logic       intN
);

  logic takeByte;
  assign takeByte = wrStrobe && readyOut && (portSel == PORT_CODE);

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeByte |=> !readyOut);

  // R1
  offport_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && readyOut && portSel != PORT_CODE) |=> readyOut);

  // R8
  read_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeByte && busIn[7] && busIn[6]) |=> ##1 !intN);

  // R8
  int_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> busOe);

  // R9
  read_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && rdStrobe && portSel == PORT_CODE) |=> intN);

endmodule

bind nibcmd_port nibcmd_port_chk #(.PORT_CODE(PORT_CODE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .portSel  (portSel),
  .busIn    (busIn),
  .wrStrobe (wrStrobe),
  .rdStrobe (rdStrobe),
  .busOe    (busOe),
  .readyOut (readyOut),
  .intN     (intN)
);

// File: tb/nibcmd_port_bench.sv
`timescale 1ns/1ps
module nibcmd_port_bench;
  localparam int GAP = 2;
  localparam logic [2:0] CMD = 3'b100;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] portSel = 3'b000;
  logic [7:0] busIn = 8'h00;
  logic       wrStrobe = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [5:0] evtIn = 6'b0;
  logic [7:0] busOut;
  logic       busOe, readyOut, intN;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nibcmd_port #(.READY_GAP(GAP), .NUM_EVT(6), .PORT_CODE(CMD)) u_nibcmd_port (
    .clk(clk), .rstN(rstN), .portSel(portSel), .busIn(busIn),
    .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .evtIn(evtIn),
    .busOut(busOut), .busOe(busOe), .readyOut(readyOut), .intN(intN));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [2:0] port, input logic [7:0] b);
    while (!readyOut) @(negedge clk);
    portSel = port; busIn = b; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; portSel = 3'b000;
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [7:0] v);
    sendByte(CMD, {2'b10, a});
    sendByte(CMD, {4'b0111, v[7:4]});
    sendByte(CMD, {4'b0000, v[3:0]});
  endtask

  task automatic readReg(input logic [5:0] a, output logic [7:0] v);
    int n;
    sendByte(CMD, {2'b11, a});
    n = 0;
    while (intN && n < 10) begin @(negedge clk); n++; end
    v = busOut;
    check(n <= 2 && busOe, "R8 read intN timing", n, 2);
    portSel = CMD; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; portSel = 3'b000;
    check(intN == 1'b1, "R9 read end", intN, 1);
  endtask

  task automatic tResetState();
    logic [7:0] v;
    check(readyOut == 1'b1, "R11 ready after reset", readyOut, 1);
    check(intN == 1'b1 && busOe == 1'b0, "R11 intN/busOe after reset", {intN, busOe}, 2);
    readReg(6'd33, v);
    check(v == 8'h00, "R11 register reset", v, 0);
  endtask

  task automatic tBasicWrite();
    logic [7:0] v;
    writeReg(6'd1, 8'hB0);
    readReg(6'd1, v);
    check(v == 8'hB0, "R3 nibble assembly", v, 8'hB0);
    writeReg(6'd63, 8'h5A);
    readReg(6'd63, v);
    check(v == 8'h5A, "R2 address field", v, 8'h5A);
  endtask

  task automatic tSeries();
    logic [7:0] v;
    sendByte(CMD, 8'h87);
    sendByte(CMD, 8'h01); sendByte(CMD, 8'h02);
    sendByte(CMD, 8'h03); sendByte(CMD, 8'h04);
    readReg(6'd7, v);
    check(v == 8'h34, "R4 series same register", v, 8'h34);
    readReg(6'd8, v);
    check(v == 8'h00, "R4 no index advance", v, 0);
  endtask

  task automatic tAbort();
    logic [7:0] v;
    sendByte(CMD, 8'h85); sendByte(CMD, 8'h0A);
    sendByte(CMD, 8'h86); sendByte(CMD, 8'h03); sendByte(CMD, 8'h04);
    readReg(6'd5, v);
    check(v == 8'h00, "R5 aborted write", v, 0);
    readReg(6'd6, v);
    check(v == 8'h34, "R5 new write after abort", v, 8'h34);
  endtask

  task automatic tStrayData();
    logic [7:0] v;
    sendByte(CMD, 8'h83); sendByte(CMD, 8'h05);
    readReg(6'd3, v);
    sendByte(CMD, 8'h07); sendByte(CMD, 8'h08);
    readReg(6'd3, v);
    check(v == 8'h00, "R6 data after read ignored", v, 0);
  endtask

  task automatic tOffPort();
    logic [7:0] v;
    sendByte(3'b000, 8'h89);
    check(readyOut == 1'b1, "R1 off-port ready stays high", readyOut, 1);
    sendByte(3'b101, 8'h01); sendByte(3'b011, 8'h02);
    readReg(6'd9, v);
    check(v == 8'h00, "R1 off-port write ignored", v, 0);
    sendByte(CMD, 8'h8A); sendByte(CMD, 8'h0B);
    sendByte(3'b000, 8'h05);
    sendByte(CMD, 8'h0C);
    readReg(6'd10, v);
    check(v == 8'hBC, "R1 off-port byte skipped", v, 8'hBC);
  endtask

  task automatic tReadyGap();
    logic [7:0] v;
    sendByte(CMD, 8'h8B);
    check(readyOut == 1'b0, "R7 ready low after accept", readyOut, 0);
    portSel = CMD; busIn = 8'h8C; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; portSel = 3'b000;
    check(readyOut == 1'b0, "R7 ready low second cycle", readyOut, 0);
    @(negedge clk);
    check(readyOut == 1'b1, "R7 ready back high", readyOut, 1);
    sendByte(CMD, 8'h01); sendByte(CMD, 8'h02);
    readReg(6'd11, v);
    check(v == 8'h12, "R7 strobe during low ignored", v, 8'h12);
    readReg(6'd12, v);
    check(v == 8'h00, "R7 ignored address", v, 0);
  endtask

  task automatic tReadOffPortStrobe();
    int n;
    writeReg(6'd20, 8'hC3);
    sendByte(CMD, 8'hD4);
    n = 0;
    while (intN && n < 10) begin @(negedge clk); n++; end
    check(busOut == 8'hC3, "R8 read data", busOut, 8'hC3);
    portSel = 3'b010; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; portSel = 3'b000;
    @(negedge clk);
    check(intN == 1'b0, "R9 off-port read strobe ignored", intN, 0);
    portSel = CMD; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; portSel = 3'b000;
    check(intN == 1'b1, "R9 read completes", intN, 1);
  endtask

  task automatic ackEvent(input int idx);
    int n;
    n = 0;
    while (intN && n < 6) begin @(negedge clk); n++; end
    check(!intN && busOe && busOut == 8'(idx), "R10 event presented", busOut, idx);
    portSel = CMD; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; portSel = 3'b000;
    check(intN == 1'b1, "R10 event cleared", intN, 1);
  endtask

  task automatic tEvents();
    int n;
    writeReg(6'd2, 8'h9E);
    sendByte(CMD, 8'hC2);
    evtIn = 6'b001010;
    @(negedge clk);
    evtIn = 6'b0;
    n = 0;
    while (intN && n < 10) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check(!intN && busOut == 8'h9E, "R10 read owns line", busOut, 8'h9E);
    portSel = CMD; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0; portSel = 3'b000;
    check(intN == 1'b1, "R9 read end before events", intN, 1);
    ackEvent(1);
    ackEvent(3);
    repeat (3) @(negedge clk);
    check(intN == 1'b1 && busOe == 1'b0, "R10 no more events", intN, 1);
    evtIn = 6'b100000;
    @(negedge clk);
    evtIn = 6'b0;
    ackEvent(5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tBasicWrite();
    tSeries();
    tAbort();
    tStrayData();
    tOffPort();
    tReadyGap();
    tReadOffPortStrobe();
    tEvents();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule